// File: doc/BRIEF.md
# DMA Burst Write Sequencer

This block is a synchronous bus master that copies a burst of words from a message buffer into shared memory. A start pulse, with a non-zero word count, makes it pull its active-low bus request low. It then waits until it samples an active-low grant on a rising clock edge. Once granted, it holds an active-low acknowledge for the whole burst. Each word takes a fixed three-clock slot. The first cycle of a slot loads the word onto the data outputs, the second pulls the write strobe low, and the third returns the strobe high while the data is still held.

At the end of the burst, request and acknowledge rise together. The data-output enable falls one clock later. On that same edge a two-clock good-block pulse starts. An in-command flag, raised at start, is then cleared. For a broadcast message it clears one edge after the good-block pulse ends. Otherwise it waits for a status-sent pulse, which marks the end of the status reply. A word index output tells the external buffer which word to present next, so the word data input can be a plain lookup on that index.

Top module: `dma_burst_writer`

## Requirements
- R1: A start pulse sampled while idle with a non-zero word count drives `req_no` low and `in_cmd_o` high on that edge. A start with a count of zero, or a start while a burst is in progress, is ignored.
- R2: While requesting, `ack_no` falls on the first rising edge at which `grant_ni` is sampled low. If grant is already low, that is the edge after request falls. Otherwise the block waits for as long as it takes. Grant is not looked at after that edge.
- R3: `ack_no` stays low for exactly 3×N cycles for a count of N. In each three-cycle slot, `wr_no` is low only in the second cycle.
- R4: On the edge that starts slot k (k counting from 0), `data_o` takes `word_data_i`. It holds that value through all three cycles of the slot, and `data_oe_o` is high during the slot.
- R5: `req_no` and `ack_no` rise on the same edge. `data_oe_o` stays high, with the last word held, for one more cycle and then falls. While `data_oe_o` is low, `data_o` reads zero.
- R6: `gbr_no` falls on the edge where `data_oe_o` falls and stays low for exactly two cycles.
- R7: For a broadcast start (`bcast_i` = 1 captured at start), `in_cmd_o` clears on the edge right after `gbr_no` rises.
- R8: For a non-broadcast start, `in_cmd_o` stays high after the good-block pulse. It clears on the first edge that samples `status_sent_i` high once `gbr_no` has been high for a cycle. `status_sent_i` has no effect at any other time.
- R9: `word_idx_o` is 0 after start. It steps by one on each edge where `wr_no` returns high and ends the burst equal to N.
- R10: A low `rst_ni` at once sets `req_no`, `ack_no`, `wr_no` and `gbr_no` high, `in_cmd_o` and `data_oe_o` low, and `word_idx_o` to zero, even in the middle of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle burst start |
| bcast_i | input | 1 | Message is broadcast, captured at start |
| status_sent_i | input | 1 | Status reply done pulse (non-broadcast) |
| grant_ni | input | 1 | Bus grant, active low |
| word_count_i | input | CNT_W | Words in the burst, captured at start |
| word_data_i | input | DATA_W | Word selected by `word_idx_o` |
| req_no | output | 1 | Bus request, active low |
| ack_no | output | 1 | Transfer acknowledge, active low |
| wr_no | output | 1 | Memory write strobe, active low |
| gbr_no | output | 1 | Good block received pulse, active low |
| in_cmd_o | output | 1 | Message in progress |
| data_oe_o | output | 1 | Enable for the data output drivers |
| data_o | output | DATA_W | Write data, zero when disabled |
| word_idx_o | output | CNT_W | Index of the word to present next |

## Verification
The word index steps on the same edge where the write strobe rises, and that edge also ends the strobe cycle. The data must not move when the index changes there, because the next word is only loaded one edge later. Bursts of one to five words are run with grant already low and with grant delayed, and the index, strobe and data are compared cycle by cycle against a slot model. The second coincidence is a start pulse, with a different count, arriving in the middle of a burst. It must leave the acknowledge length, strobes and index unchanged.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_XFER,
    ST_REL,
    ST_GBR_A,
    ST_GBR_B,
    ST_POST,
    ST_WSTAT
  } seq_state_e;

  // position inside a three-cycle word slot
  localparam logic [1:0] PH_LOAD   = 2'd0;
  localparam logic [1:0] PH_STROBE = 2'd1;
  localparam logic [1:0] PH_HOLD   = 2'd2;

endpackage

// File: rtl/dma_slot_timer.sv
module dma_slot_timer
  import dma_burst_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [1:0]       phase_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             last_o
);

  logic [1:0]       phase_q;
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_LOAD;
      idx_q   <= '0;
      count_q <= '0;
    end else begin
      if (arm_i) begin
        count_q <= count_i;
        idx_q   <= '0;
      end else if (run_i && phase_q == PH_STROBE) begin
        idx_q <= idx_q + 1'b1;
      end

      if (!run_i || phase_q == PH_HOLD) phase_q <= PH_LOAD;
      else                               phase_q <= phase_q + 1'b1;
    end
  end

  // the index already points past the word being finished in the hold cycle
  assign last_o  = run_i && (phase_q == PH_HOLD) && (idx_q == count_q);
  assign phase_o = phase_q;
  assign idx_o   = idx_q;

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_burst_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       count_nz_i,
  input  logic       bcast_i,
  input  logic       grant_ni,
  input  logic       status_sent_i,
  input  logic       last_i,
  output seq_state_e state_o,
  output logic       arm_o
);

  seq_state_e state_q, state_d;
  logic       bcast_q;

  assign arm_o = (state_q == ST_IDLE) && start_i && count_nz_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (arm_o) state_d = ST_REQ;
      ST_REQ:   if (!grant_ni) state_d = ST_XFER;
      ST_XFER:  if (last_i) state_d = ST_REL;
      ST_REL:   state_d = ST_GBR_A;
      ST_GBR_A: state_d = ST_GBR_B;
      ST_GBR_B: state_d = ST_POST;
      ST_POST:  state_d = bcast_q ? ST_IDLE : ST_WSTAT;
      ST_WSTAT: if (status_sent_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bcast_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (arm_o) bcast_q <= bcast_i;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/dma_word_reg.sv
module dma_word_reg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              drop_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] data_o,
  output logic              oe_o
);

  logic [DATA_W-1:0] word_q;
  logic              oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      if (load_i) begin
        word_q <= word_i;
        oe_q   <= 1'b1;
      end else if (drop_i) begin
        oe_q <= 1'b0;
      end
    end
  end

  assign data_o = oe_q ? word_q : '0;
  assign oe_o   = oe_q;

endmodule

// File: rtl/dma_burst_writer.sv
module dma_burst_writer
  import dma_burst_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              bcast_i,
  input  logic              status_sent_i,
  input  logic              grant_ni,
  input  logic [CNT_W-1:0]  word_count_i,
  input  logic [DATA_W-1:0] word_data_i,
  output logic              req_no,
  output logic              ack_no,
  output logic              wr_no,
  output logic              gbr_no,
  output logic              in_cmd_o,
  output logic              data_oe_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CNT_W-1:0]  word_idx_o
);

  seq_state_e state;
  logic       arm, last, run, load;
  logic [1:0] phase;

  dma_seq_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .count_nz_i    (|word_count_i),
    .bcast_i       (bcast_i),
    .grant_ni      (grant_ni),
    .status_sent_i (status_sent_i),
    .last_i        (last),
    .state_o       (state),
    .arm_o         (arm)
  );

  assign run = (state == ST_XFER);

  dma_slot_timer #(.CNT_W(CNT_W)) u_slot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm),
    .run_i   (run),
    .count_i (word_count_i),
    .phase_o (phase),
    .idx_o   (word_idx_o),
    .last_o  (last)
  );

  // first word loads on the grant edge, later words at each slot boundary
  assign load = ((state == ST_REQ) && !grant_ni) ||
                (run && (phase == PH_HOLD) && !last);

  dma_word_reg #(.DATA_W(DATA_W)) u_word (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .drop_i (state == ST_REL),
    .word_i (word_data_i),
    .data_o (data_o),
    .oe_o   (data_oe_o)
  );

  assign req_no   = !((state == ST_REQ) || run);
  assign ack_no   = !run;
  assign wr_no    = !(run && (phase == PH_STROBE));
  assign gbr_no   = !((state == ST_GBR_A) || (state == ST_GBR_B));
  assign in_cmd_o = (state != ST_IDLE);

endmodule

// File: rtl/dma_burst_writer_chk.sv
module dma_burst_writer_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              grant_ni,
  input logic              req_no,
  input logic              ack_no,
  input logic              wr_no,
  input logic              gbr_no,
  input logic              in_cmd_o,
  input logic              data_oe_o,
  input logic [DATA_W-1:0] data_o,
  input logic [CNT_W-1:0]  word_idx_o
);

  // R1
  ack_under_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_no |-> !req_no);

  // R2
  ack_after_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_no) |-> (!$past(grant_ni) && !$past(req_no)));

  // R3
  wr_in_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> !ack_no);

  // R3
  wr_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_no) |=> wr_no);

  // R4
  data_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_no || $rose(wr_no)) |-> ($stable(data_o) && data_oe_o));

  // R5
  joint_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_no) |-> ($rose(req_no) && data_oe_o));

  // R5
  oe_late_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_no) |=> !data_oe_o);

  // R6
  gbr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gbr_no) |=> !gbr_no);

  // R6
  gbr_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gbr_no && $past(!gbr_no)) |=> gbr_no);

  // R7
  cmd_after_gbr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_cmd_o) |-> (gbr_no && $past(gbr_no) && req_no));

  // R9
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_no) |-> (word_idx_o == CNT_W'($past(word_idx_o) + 1'b1)));

endmodule

bind dma_burst_writer dma_burst_writer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .grant_ni   (grant_ni),
  .req_no     (req_no),
  .ack_no     (ack_no),
  .wr_no      (wr_no),
  .gbr_no     (gbr_no),
  .in_cmd_o   (in_cmd_o),
  .data_oe_o  (data_oe_o),
  .data_o     (data_o),
  .word_idx_o (word_idx_o)
);

// File: tb/dma_burst_writer_bench.sv
module dma_burst_writer_bench;

  localparam int DATA_W = 16;
  localparam int CNT_W  = 6;
  localparam int NVEC   = 6;

  // vector: [15:10] count, [9] bcast, [8:5] grant delay, [4:1] status delay, [0] mid-burst start
  localparam logic [15:0] VEC [NVEC] = '{
    {6'd1, 1'b1, 4'd0, 4'd0, 1'b0},
    {6'd2, 1'b1, 4'd0, 4'd0, 1'b0},
    {6'd3, 1'b0, 4'd2, 4'd5, 1'b0},
    {6'd4, 1'b0, 4'd0, 4'd0, 1'b1},
    {6'd1, 1'b0, 4'd5, 4'd0, 1'b1},
    {6'd5, 1'b1, 4'd1, 4'd0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              start, bcast, status, grant_n;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] wdata;
  logic              req_n, ack_n, wr_n, gbr_n, in_cmd, oe;
  logic [DATA_W-1:0] dout;
  logic [CNT_W-1:0]  idx;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  function automatic logic [DATA_W-1:0] fword(input int k);
    return 16'hA500 ^ 16'(k * 257);
  endfunction

  assign wdata = fword(int'(idx));

  dma_burst_writer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dma_burst_writer (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .start_i       (start),
    .bcast_i       (bcast),
    .status_sent_i (status),
    .grant_ni      (grant_n),
    .word_count_i  (count),
    .word_data_i   (wdata),
    .req_no        (req_n),
    .ack_no        (ack_n),
    .wr_no         (wr_n),
    .gbr_no        (gbr_n),
    .in_cmd_o      (in_cmd),
    .data_oe_o     (oe),
    .data_o        (dout),
    .word_idx_o    (idx)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h exp %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, "req_no", req_n, 1);
    chk(tag, "ack_no", ack_n, 1);
    chk(tag, "wr_no", wr_n, 1);
    chk(tag, "gbr_no", gbr_n, 1);
    chk(tag, "in_cmd", in_cmd, 0);
    chk(tag, "data_oe", oe, 0);
  endtask

  task automatic run_vec(input int n, input bit bc, input int gd, input int sd, input bit poke);
    int a, e, s, fin, k, p;
    grant_n = (gd == 0) ? 1'b0 : 1'b1;
    count = CNT_W'(n);
    bcast = bc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    count = 6'd7;
    bcast = ~bc;
    chk("R1", "req_no after start", req_n, 0);
    chk("R1", "in_cmd after start", in_cmd, 1);
    chk("R9", "idx after start", idx, 0);
    a = gd + 1;
    e = a + 3 * n;
    s = e + 4 + sd;
    fin = bc ? e + 4 : s + 1;
    for (int c = 1; c <= fin + 2; c++) begin
      @(negedge clk);
      if (c == a - 1) chk("R2", "ack before grant seen", ack_n, 1);
      if (c == a) chk("R2", "ack on grant edge", ack_n, 0);
      chk("R5", "req_no", req_n, (c < e) ? 0 : 1);
      chk("R3", "ack_no", ack_n, (c >= a && c < e) ? 0 : 1);
      chk("R6", "gbr_no", gbr_n, (c == e + 1 || c == e + 2) ? 0 : 1);
      chk(bc ? "R7" : "R8", "in_cmd", in_cmd, (c < fin) ? 1 : 0);
      if (c >= a && c < e) begin
        k = (c - a) / 3;
        p = (c - a) % 3;
        chk("R3", "wr_no", wr_n, (p == 1) ? 0 : 1);
        chk("R4", "data", dout, fword(k));
        chk("R4", "data_oe", oe, 1);
        chk("R9", "idx", idx, (p == 2) ? k + 1 : k);
      end else begin
        chk("R3", "wr_no idle", wr_n, 1);
        chk("R5", "data_oe", oe, (c == e) ? 1 : 0);
        chk("R5", "data", dout, (c == e) ? fword(n - 1) : 0);
        chk("R9", "idx", idx, (c < a) ? 0 : n);
      end
      if (gd > 0 && c == gd) grant_n = 1'b0;
      if (c == e) grant_n = 1'b1;
      if (poke && c == a + 1) begin start = 1'b1; count = 6'd3; end
      if (poke && c == a + 2) start = 1'b0;
      status = (!bc && c == s) ? 1'b1 : 1'b0;
    end
    status = 1'b0;
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R1 run hung: got running exp finished");
    finish_run();
  end

  initial begin
    start = 0; bcast = 0; status = 0; grant_n = 1; count = '0;
    repeat (3) @(negedge clk);
    chk_idle("R10");
    chk("R10", "idx in reset", idx, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R10");

    for (int v = 0; v < NVEC; v++)
      run_vec(int'(VEC[v][15:10]), VEC[v][9], int'(VEC[v][8:5]), int'(VEC[v][4:1]), VEC[v][0]);

    // R1: zero count start is ignored
    grant_n = 1'b0;
    count = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) begin
      chk_idle("R1");
      @(negedge clk);
    end
    grant_n = 1'b1;

    // R8: status pulse while idle has no effect
    status = 1'b1;
    @(negedge clk);
    status = 1'b0;
    @(negedge clk);
    chk_idle("R8");

    // R10: reset in the middle of a burst
    grant_n = 1'b0;
    count = 6'd4;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10", "ack low before reset", ack_n, 0);
    rst_n = 1'b0;
    #1;
    chk_idle("R10");
    chk("R10", "idx cleared", idx, 0);
    @(negedge clk);
    rst_n = 1'b1;
    grant_n = 1'b1;
    @(negedge clk);
    chk_idle("R10");

    run_vec(2, 1'b1, 0, 0, 1'b0);
    finish_run();
  end

endmodule